// File: doc/BRIEF.md
# SATA Host Controller Register Block

This block is the memory-mapped control and status register set of a small SATA host controller with up to four ports. A processor reaches it through a simple 32-bit word bus. A few global registers describe the controller and aggregate interrupts. Each port has its own window of registers: interrupt status and enable, command, task-file status, signature, link status, control, error, active tags and issued commands. Port-side hardware reports events through a sideband input that sets interrupt-status and link-error bits.

The registers do not all behave the same way on a write. Some bits clear when written with ones, some set, one register keeps only the bits in a fixed mask, and the command register computes its own running bits. Writing the detect field of a port's link control from 1 to 0 resets that port. A global control write with bit 0 set resets the whole block. The single interrupt output follows the global status register, gated by an enable bit.

Top module: `sata_hba_regs`

## Requirements
- R1: Only address bits 11:0 are decoded, so addresses alias every 0x1000 bytes. A write whose bits 1:0 are non-zero has no effect. Reads ignore bits 1:0.
- R2: Port i occupies 0x100+0x80*i to 0x17F+0x80*i. Global registers sit below 0x100. Unassigned global offsets, and any offset at or above 0x100+0x80*NPORTS, read zero and ignore writes.
- R3: Three global registers are read-only and ignore writes. Capabilities at 0x00 reads NPORTS-1 in bits 4:0, 31 in bits 12:8, 1 in bits 23:20, and has bits 18 and 30 set. Ports-implemented at 0x0C reads (1<<NPORTS)-1. Version at 0x10 reads 0x00010000.
- R4: Global control at 0x04 reads 0x80000000 after reset. A write with bit 0 set returns every register of the block to its reset value. Any other write stores (value & 3) | 0x80000000.
- R5: Port interrupt status at offset 0x10 is write-1-to-clear. Event input bits are ORed into it.
- R6: Port interrupt enable at offset 0x14 stores the written value ANDed with 0xFDC000FF.
- R7: A write to port command at offset 0x18 stores the value with bits 15 and 14 replaced. Bit 15 becomes a copy of bit 0 (start), and bit 14 becomes a copy of bit 4 (receive enable).
- R8: Task-file data at offset 0x20 keeps written bits 15:0 and reads them back with zeros above. Signature at offset 0x24 is a plain read/write register.
- R9: Link status at offset 0x28 reads 0x00000113 when the port's drive-present input is high and 0 when it is low. Writes to it have no effect.
- R10: Link error at offset 0x30 is write-1-to-clear, and event error bits are ORed into it. Active tags at offset 0x34 and command issue at offset 0x38 are write-1-to-set.
- R11: Consider a write to link control at offset 0x2C that lands while bits 3:0 hold 1 and carries 0 in bits 3:0. It clears that port's interrupt status, interrupt enable, link error and active tags, and leaves its other registers alone. Link control always takes the written value.
- R12: Global interrupt status at 0x08 sets bit i one cycle after port i has a bit set in both interrupt status and enable. It is write-1-to-clear, but the bit sets again while that condition holds. Output irq is high exactly when this register is non-zero and global control bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_valid | input | 1 | Event strobe from port-side hardware |
| evt_port | input | PIDX_W | Port that receives the event |
| evt_irq_bits | input | 32 | Bits to set in that port's interrupt status |
| evt_err_bits | input | 32 | Bits to set in that port's link error |
| drive_present | input | NPORTS | One per port: drive attached |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit in a port's stored state shows on the next read of that register. It also reaches the interrupt output through the status-and-enable product one cycle later, when the global bit follows. A stuck running bit or a missed write mask shows on the first readback after the command or enable write. A lost detect-field edge shows only as active tags or enable bits that survive the reset write. A wrong window decode shows as data written through one port becoming visible in another port or in the aliased and unassigned regions.

// File: rtl/sata_regs_pkg.sv
package sata_regs_pkg;

    // port register word indices (offset >> 2) inside a 0x80 window
    localparam logic [4:0] PW_IRQ_STS  = 5'd4;
    localparam logic [4:0] PW_IRQ_EN   = 5'd5;
    localparam logic [4:0] PW_CMD      = 5'd6;
    localparam logic [4:0] PW_TASKFILE = 5'd8;
    localparam logic [4:0] PW_SIG      = 5'd9;
    localparam logic [4:0] PW_LNK_STS  = 5'd10;
    localparam logic [4:0] PW_LNK_CTL  = 5'd11;
    localparam logic [4:0] PW_LNK_ERR  = 5'd12;
    localparam logic [4:0] PW_ACTIVE   = 5'd13;
    localparam logic [4:0] PW_ISSUE    = 5'd14;

    // global register word indices
    localparam logic [5:0] GW_CAPS    = 6'd0;
    localparam logic [5:0] GW_CTRL    = 6'd1;
    localparam logic [5:0] GW_IRQ_STS = 6'd2;
    localparam logic [5:0] GW_IMPL    = 6'd3;
    localparam logic [5:0] GW_VER     = 6'd4;

    localparam logic [31:0] IRQ_EN_MASK   = 32'hFDC0_00FF;
    localparam logic [31:0] CTRL_RST_VAL  = 32'h8000_0000;
    localparam logic [31:0] VERSION_VAL   = 32'h0001_0000;
    localparam logic [31:0] LINK_UP_VAL   = 32'h0000_0113;
    localparam int          CMD_START_BIT = 0;
    localparam int          CMD_RXEN_BIT  = 4;
    localparam int          CMD_RXRUN_BIT = 14;
    localparam int          CMD_RUN_BIT   = 15;

    typedef struct packed {
        logic [31:0] irq_sts;
        logic [31:0] irq_en;
        logic [31:0] cmd;
        logic [15:0] taskfile;
        logic [31:0] sig;
        logic [31:0] lnk_ctl;
        logic [31:0] lnk_err;
        logic [31:0] active;
        logic [31:0] issue;
    } port_state_t;

    function automatic logic [31:0] caps_value(input int nports);
        logic [31:0] v;
        v        = 32'h4014_1F00;
        v[4:0]   = 5'(nports - 1);
        return v;
    endfunction

    function automatic logic [31:0] cmd_value(input logic [31:0] w);
        logic [31:0] v;
        v                = w;
        v[CMD_RUN_BIT]   = w[CMD_START_BIT];
        v[CMD_RXRUN_BIT] = w[CMD_RXEN_BIT];
        return v;
    endfunction

endpackage

// File: rtl/sata_port_regs.sv
module sata_port_regs
    import sata_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [4:0]  wr_word,
    input  logic [31:0] wr_data,
    input  logic [4:0]  rd_word,
    output logic [31:0] rd_data,
    input  logic        evt_valid,
    input  logic [31:0] evt_irq_bits,
    input  logic [31:0] evt_err_bits,
    input  logic        present,
    output logic        pend
);
    port_state_t q, d;
    logic [31:0] ev_irq, ev_err;
    logic        det_drop;

    assign ev_irq   = evt_valid ? evt_irq_bits : '0;
    assign ev_err   = evt_valid ? evt_err_bits : '0;
    assign det_drop = (q.lnk_ctl[3:0] == 4'd1) && (wr_data[3:0] == 4'd0);

    always_comb begin
        d         = q;
        d.irq_sts = q.irq_sts | ev_irq;
        d.lnk_err = q.lnk_err | ev_err;
        if (wr_en) begin
            case (wr_word)
                PW_IRQ_STS:  d.irq_sts  = (q.irq_sts & ~wr_data) | ev_irq;
                PW_IRQ_EN:   d.irq_en   = wr_data & IRQ_EN_MASK;
                PW_CMD:      d.cmd      = cmd_value(wr_data);
                PW_TASKFILE: d.taskfile = wr_data[15:0];
                PW_SIG:      d.sig      = wr_data;
                PW_LNK_ERR:  d.lnk_err  = (q.lnk_err & ~wr_data) | ev_err;
                PW_ACTIVE:   d.active   = q.active | wr_data;
                PW_ISSUE:    d.issue    = q.issue | wr_data;
                PW_LNK_CTL: begin
                    d.lnk_ctl = wr_data;
                    if (det_drop) begin
                        d.irq_sts = '0;
                        d.irq_en  = '0;
                        d.lnk_err = '0;
                        d.active  = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign pend = |(q.irq_sts & q.irq_en);

    always_comb begin
        case (rd_word)
            PW_IRQ_STS:  rd_data = q.irq_sts;
            PW_IRQ_EN:   rd_data = q.irq_en;
            PW_CMD:      rd_data = q.cmd;
            PW_TASKFILE: rd_data = {16'h0, q.taskfile};
            PW_SIG:      rd_data = q.sig;
            PW_LNK_STS:  rd_data = present ? LINK_UP_VAL : '0;
            PW_LNK_CTL:  rd_data = q.lnk_ctl;
            PW_LNK_ERR:  rd_data = q.lnk_err;
            PW_ACTIVE:   rd_data = q.active;
            PW_ISSUE:    rd_data = q.issue;
            default:     rd_data = '0;
        endcase
    end

    assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word == PW_IRQ_STS && !evt_valid) |=> ((q.irq_sts & $past(wr_data)) == '0));

    assert_en_mask_R6: assert property (@(posedge clk) disable iff (rst)
        (q.irq_en & ~IRQ_EN_MASK) == '0);

    assert_run_bits_R7: assert property (@(posedge clk) disable iff (rst)
        (q.cmd[CMD_RUN_BIT] == q.cmd[CMD_START_BIT]) && (q.cmd[CMD_RXRUN_BIT] == q.cmd[CMD_RXEN_BIT]));

    assert_det_reset_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word == PW_LNK_CTL && det_drop) |=> (q.active == '0 && q.irq_en == '0));

    assert_set_only_R10: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && wr_word == PW_LNK_CTL)) |=> ((q.active & $past(q.active)) == $past(q.active)));
endmodule

// File: rtl/sata_global_regs.sv
module sata_global_regs
    import sata_regs_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [5:0]        wr_word,
    input  logic [31:0]       wr_data,
    input  logic [5:0]        rd_word,
    output logic [31:0]       rd_data,
    input  logic [NPORTS-1:0] pend,
    output logic              soft_rst,
    output logic              irq
);
    localparam logic [31:0] IMPL_VAL = 32'((64'd1 << NPORTS) - 64'd1);

    logic [31:0]       ctrl_q;
    logic [NPORTS-1:0] gis_q;

    assign soft_rst = wr_en && (wr_word == GW_CTRL) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            ctrl_q <= CTRL_RST_VAL;
            gis_q  <= '0;
        end else begin
            if (wr_en && wr_word == GW_CTRL)
                ctrl_q <= CTRL_RST_VAL | {30'h0, wr_data[1:0]};
            if (wr_en && wr_word == GW_IRQ_STS)
                gis_q <= (gis_q & ~wr_data[NPORTS-1:0]) | pend;
            else
                gis_q <= gis_q | pend;
        end
    end

    assign irq = (|gis_q) && ctrl_q[1];

    always_comb begin
        case (rd_word)
            GW_CAPS:    rd_data = caps_value(NPORTS);
            GW_CTRL:    rd_data = ctrl_q;
            GW_IRQ_STS: rd_data = {{(32-NPORTS){1'b0}}, gis_q};
            GW_IMPL:    rd_data = IMPL_VAL;
            GW_VER:     rd_data = VERSION_VAL;
            default:    rd_data = '0;
        endcase
    end

    assert_gis_follow_R12: assert property (@(posedge clk) disable iff (rst)
        !soft_rst |=> ((gis_q & $past(pend)) == $past(pend)));

    assert_ctrl_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[31] && ctrl_q[30:2] == '0);
endmodule

// File: rtl/sata_hba_regs.sv
module sata_hba_regs
    import sata_regs_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              evt_valid,
    input  logic [PIDX_W-1:0] evt_port,
    input  logic [31:0]       evt_irq_bits,
    input  logic [31:0]       evt_err_bits,
    input  logic [NPORTS-1:0] drive_present,
    output logic              irq
);
    localparam logic [11:0] PORT_BASE = 12'h100;

    logic [11:0]       off;
    logic [11:0]       rel;
    logic [4:0]        pidx;
    logic              aligned, in_glob, in_port, wr_ok, soft_rst, port_rst;
    logic [31:0]       glob_rd;
    logic [31:0]       port_rd [NPORTS];
    logic [NPORTS-1:0] pend;

    assign off      = bus_addr[11:0];
    assign rel      = off - PORT_BASE;
    assign pidx     = rel[11:7];
    assign aligned  = (off[1:0] == 2'b00);
    assign in_glob  = (off < PORT_BASE);
    assign in_port  = !in_glob && (32'(pidx) < NPORTS);
    assign wr_ok    = bus_we && aligned;
    assign port_rst = rst || soft_rst;

    sata_global_regs #(.NPORTS(NPORTS)) u_global (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_ok && in_glob),
        .wr_word  (off[7:2]),
        .wr_data  (bus_wdata),
        .rd_word  (off[7:2]),
        .rd_data  (glob_rd),
        .pend     (pend),
        .soft_rst (soft_rst),
        .irq      (irq)
    );

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        logic sel;
        assign sel = in_port && (pidx == 5'(i));
        sata_port_regs u_port (
            .clk          (clk),
            .rst          (port_rst),
            .wr_en        (wr_ok && sel),
            .wr_word      (off[6:2]),
            .wr_data      (bus_wdata),
            .rd_word      (off[6:2]),
            .rd_data      (port_rd[i]),
            .evt_valid    (evt_valid && (32'(evt_port) == i)),
            .evt_irq_bits (evt_irq_bits),
            .evt_err_bits (evt_err_bits),
            .present      (drive_present[i]),
            .pend         (pend[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (in_glob) begin
            bus_rdata = glob_rd;
        end else begin
            for (int i = 0; i < NPORTS; i++)
                if (in_port && pidx == 5'(i)) bus_rdata = port_rd[i];
        end
    end

    assert_irq_off_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && aligned && off == 12'h004 && !bus_wdata[1]) |=> !irq);

    assert_irq_source_R12: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(|pend) || $past(irq) || $past(bus_we));
endmodule

// File: tb/tb_sata_hba_regs.sv
`timescale 1ns/1ps
module tb_sata_hba_regs;
    localparam int NP = 2;

    logic        clk = 0;
    logic        rst = 1;
    logic [31:0] bus_addr = 0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        evt_valid = 0;
    logic [0:0]  evt_port = 0;
    logic [31:0] evt_irq_bits = 0;
    logic [31:0] evt_err_bits = 0;
    logic [NP-1:0] drive_present = 2'b01;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    sata_hba_regs #(.NPORTS(NP)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_valid(evt_valid),
        .evt_port(evt_port), .evt_irq_bits(evt_irq_bits), .evt_err_bits(evt_err_bits),
        .drive_present(drive_present), .irq(irq)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic ev(input logic p, input logic [31:0] ib, input logic [31:0] eb);
        @(negedge clk);
        evt_valid = 1; evt_port = p; evt_irq_bits = ib; evt_err_bits = eb;
        @(negedge clk);
        evt_valid = 0;
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // reset state and identity registers
        rd(32'h004, r); chk("R4 ctrl reset", r, 32'h8000_0000);
        rd(32'h000, r); chk("R3 caps", r, 32'h4014_1F01);
        rd(32'h00C, r); chk("R3 impl", r, 32'h3);
        rd(32'h010, r); chk("R3 version", r, 32'h0001_0000);
        chk("R12 irq reset", {31'h0, irq}, 0);
        wr(32'h000, 32'hFFFF_FFFF); wr(32'h00C, 0); wr(32'h010, 0);
        rd(32'h000, r); chk("R3 caps ro", r, 32'h4014_1F01);
        rd(32'h00C, r); chk("R3 impl ro", r, 32'h3);
        rd(32'h010, r); chk("R3 version ro", r, 32'h0001_0000);

        // enable mask and taskfile/signature sweeps on both ports
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < 8; k++) begin
                logic [31:0] v, b;
                b = 32'h100 + 32'(p) * 32'h80;
                v = 32'h9E37_79B9 * 32'(k + 1) + 32'(p);
                wr(b + 32'h14, v);
                rd(b + 32'h14, r); chk("R6 enable mask", r, v & 32'hFDC0_00FF);
                wr(b + 32'h20, v);
                rd(b + 32'h20, r); chk("R8 taskfile", r, v & 32'hFFFF);
                wr(b + 32'h24, ~v);
                rd(b + 32'h24, r); chk("R8 signature", r, ~v);
            end
            wr(32'h100 + 32'(p) * 32'h80 + 32'h14, 0);
        end

        // command register running bits
        for (int k = 0; k < 16; k++) begin
            logic [31:0] v, e;
            v = (32'h0123_C0A0 * 32'(k + 3)) & ~32'h11;
            v[0] = k[0]; v[4] = k[1];
            if (k[2]) v[15:14] = 2'b11;
            e = v & ~32'hC000;
            if (v[0]) e[15] = 1'b1;
            if (v[4]) e[14] = 1'b1;
            wr(32'h118, v);
            rd(32'h118, r); chk("R7 command bits", r, e);
        end

        // link status derived from presence
        rd(32'h128, r); chk("R9 present", r, 32'h113);
        rd(32'h1A8, r); chk("R9 absent", r, 0);
        wr(32'h1A8, 32'hFFFF); rd(32'h1A8, r); chk("R9 write ignored", r, 0);

        // active / issue set-only, error W1C
        wr(32'h134, 32'h5); wr(32'h134, 32'h2); rd(32'h134, r); chk("R10 active set", r, 32'h7);
        wr(32'h134, 0);    rd(32'h134, r); chk("R10 active zero write", r, 32'h7);
        wr(32'h138, 32'h80); wr(32'h138, 32'h1); rd(32'h138, r); chk("R10 issue set", r, 32'h81);
        ev(0, 0, 32'hF0);  rd(32'h130, r); chk("R10 error event", r, 32'hF0);
        wr(32'h130, 32'h30); rd(32'h130, r); chk("R10 error W1C", r, 32'hC0);

        // port interrupt status W1C, masked event leaves global clear
        ev(0, 32'h0000_0041, 0);
        rd(32'h110, r); chk("R5 event set", r, 32'h41);
        @(negedge clk);
        rd(32'h008, r); chk("R12 disabled port no global", r, 0);
        wr(32'h110, 32'h01); rd(32'h110, r); chk("R5 W1C", r, 32'h40);
        wr(32'h110, 32'h40); rd(32'h110, r); chk("R5 W1C all", r, 0);

        // global aggregation through port 1
        wr(32'h194, 32'h1);
        wr(32'h004, 32'h2);
        rd(32'h004, r); chk("R4 ctrl store", r, 32'h8000_0002);
        chk("R12 no irq idle", {31'h0, irq}, 0);
        ev(1, 32'h1, 0);
        @(negedge clk);
        rd(32'h008, r); chk("R12 global bit", r, 32'h2);
        chk("R12 irq high", {31'h0, irq}, 1);
        wr(32'h008, 32'h2); rd(32'h008, r); chk("R12 resets while pending", r, 32'h2);
        wr(32'h004, 32'h0); chk("R12 irq gated", {31'h0, irq}, 0);
        rd(32'h008, r); chk("R12 gis kept", r, 32'h2);
        wr(32'h004, 32'h2); chk("R12 irq back", {31'h0, irq}, 1);
        wr(32'h190, 32'h1); wr(32'h008, 32'h2);
        rd(32'h008, r); chk("R12 gis cleared", r, 0);
        chk("R12 irq low", {31'h0, irq}, 0);

        // detect field reset
        wr(32'h12C, 32'h1); wr(32'h114, 32'hFF); ev(0, 32'h4, 32'h8);
        wr(32'h12C, 32'h300);
        rd(32'h114, r); chk("R11 enable cleared", r, 0);
        rd(32'h134, r); chk("R11 active cleared", r, 0);
        rd(32'h110, r); chk("R11 status cleared", r, 0);
        rd(32'h130, r); chk("R11 error cleared", r, 0);
        rd(32'h12C, r); chk("R11 ctl stored", r, 32'h300);
        rd(32'h138, r); chk("R11 issue kept", r, 32'h81);
        wr(32'h12C, 32'h2); wr(32'h134, 32'h1); wr(32'h12C, 32'h0);
        rd(32'h134, r); chk("R11 no reset from 2", r, 32'h1);

        // alignment, aliasing and decode bounds
        wr(32'h125, 32'hDEAD); rd(32'h124, r); chk("R1 misaligned ignored", r, ~(32'h9E37_79B9 * 32'd8));
        wr(32'h5124, 32'hCAFE); rd(32'h124, r); chk("R1 alias write", r, 32'hCAFE);
        rd(32'h7126, r); chk("R1 alias read low bits", r, 32'hCAFE);
        wr(32'h224, 32'h1234); rd(32'h224, r); chk("R2 beyond ports", r, 0);
        rd(32'h1A4, r); chk("R2 port1 untouched", r, ~(32'h9E37_79B9 * 32'd8 + 32'd1));
        wr(32'h040, 32'h1); rd(32'h040, r); chk("R2 unassigned global", r, 0);
        rd(32'h17C, r); chk("R2 unassigned port word", r, 0);

        // controller reset through global control
        wr(32'h134, 32'h10);
        wr(32'h004, 32'h3);
        rd(32'h004, r); chk("R4 soft reset ctrl", r, 32'h8000_0000);
        rd(32'h124, r); chk("R4 soft reset sig", r, 0);
        rd(32'h134, r); chk("R4 soft reset active", r, 0);
        rd(32'h118, r); chk("R4 soft reset cmd", r, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule